// File: doc/BRIEF.md
# Dual Phase-Shifted PWM DAC Generator

This block drives two pulse-width outputs that an external resistor pair adds together before an analog low-pass filter. Both channels repeat with the same programmable period. The lagging channel runs a fixed fraction of a period behind the leading one, nominally half a period. Adding the two waveforms cancels the ripple component at the PWM fundamental. The first ripple term left at the filter input then sits at twice the PWM rate, so the same filter leaves less ripple, or a faster filter gives the same ripple.

The conversion value is one bit wider than a single channel's duty field. Its upper bits set a base duty for both channels. Its lowest bit gives the leading channel one extra count, which produces the half-step between two neighbouring levels. The period, the phase trim and the value are held in shadow registers that change only at the leading channel's period boundary. A strobe marks that boundary.

Top module: `pwm_dual_phase_dac`

## Requirements
- R1: During reset, and from the first clock edge at which `enable` is sampled low, both PWM outputs and `cycle_start` are low. Both counters are cleared.
- R2: While running, the leading counter steps 0, 1, ..., `period` and then returns to 0, so one PWM period lasts `period`+1 clocks. `cycle_start` is high exactly while the leading counter is 0.
- R3: Each output is high while its own counter is strictly less than its duty. A duty of 0 keeps the output low, and a duty above `period` keeps it high.
- R4: The duty split: base = `code` >> 1. The lagging duty equals base. The leading duty equals base + `code[0]`, saturated at the largest value a duty field can hold. The two duties therefore never differ by more than one count.
- R5: The phase offset is floor((`period`+1)/2) − `trim`, clamped at 0 when `trim` exceeds the half value. The lagging counter always equals (leading counter − offset) modulo (`period`+1).
- R6: On the first clock edge at which `enable` is sampled high while idle, the leading counter loads 0 and the lagging counter loads its lagged value in the same cycle. The R5 relation therefore holds from the first period.
- R7: `period`, `code` and `trim` are captured only on that start edge and on the edge at which the leading counter wraps from `period` to 0. A change between those edges has no effect on the outputs until the next wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run request; low holds the block idle |
| period | input | CW | Terminal count shared by both channels |
| code | input | CW+2 | Conversion value: upper bits are the base duty, bit 0 is the half-step |
| trim | input | TW | Counts removed from the nominal half-period offset |
| pwm_lead | output | 1 | Leading channel output |
| pwm_lag | output | 1 | Lagging channel output |
| cycle_start | output | 1 | High while the leading counter is at 0 |

## Verification
Several properties are checked on every cycle. Both counters stay within the terminal count. The two duties stay within one count of each other. At each period boundary the lagging counter sits exactly one offset behind. Shadow values hold still away from the boundary. The idle state follows one edge after `enable` falls. Other behaviour is only visible in bench scenarios: the exact pulse widths seen at the pins for every code at several periods, the saturation of the extra count, clamping of an oversized trim, and the deferral of a code change made partway through a period.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
    localparam int NUM_CH  = 2;
    localparam int CH_LEAD = 0;
    localparam int CH_LAG  = 1;
endpackage

// File: rtl/pwm_code_split.sv
module pwm_code_split #(
    parameter int DW = 11
) (
    input  logic [DW:0]   code,
    output logic [DW-1:0] duty_lead,
    output logic [DW-1:0] duty_lag
);
    logic [DW-1:0] base;
    logic [DW:0]   sum;

    always_comb begin
        base = code[DW:1];
        sum  = {1'b0, base} + {{DW{1'b0}}, code[0]};
        // saturate so the half-step never wraps the lead duty to zero
        duty_lead = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
        duty_lag  = base;
    end

    always_comb begin
        assert (duty_lead == duty_lag || duty_lead == duty_lag + 1'b1
                || duty_lag == {DW{1'b1}})
            else $error("AST_SPLIT_STEP violated"); // R4
    end
endmodule

// File: rtl/pwm_phase_offset.sv
module pwm_phase_offset #(
    parameter int CW = 10,
    parameter int TW = 8
) (
    input  logic [CW-1:0] period,
    input  logic [TW-1:0] trim,
    output logic [CW-1:0] offset,
    output logic [CW-1:0] lag_start
);
    localparam int XW = CW + 1;

    logic [XW-1:0] half_w;
    logic [XW-1:0] trim_w;
    logic [XW-1:0] off_w;
    logic [XW-1:0] span_w;
    logic [XW-1:0] start_w;

    always_comb begin
        span_w  = {1'b0, period} + XW'(1);
        half_w  = span_w >> 1;
        trim_w  = XW'(trim);
        off_w   = (trim_w > half_w) ? '0 : half_w - trim_w;
        start_w = (off_w == '0) ? '0 : span_w - off_w;
        offset    = off_w[CW-1:0];
        lag_start = start_w[CW-1:0];
    end

    always_comb begin
        assert (start_w <= {1'b0, period})
            else $error("AST_LAG_START_RANGE violated"); // R5
    end
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
    parameter int CW = 10
) (
    input  logic          run,
    input  logic [CW-1:0] cnt,
    input  logic [CW:0]   duty,
    output logic          pwm
);
    always_comb begin
        pwm = run && ({1'b0, cnt} < duty);
    end
endmodule

// File: rtl/pwm_dual_phase_dac.sv
module pwm_dual_phase_dac #(
    parameter int CW = 10,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [CW-1:0] period,
    input  logic [CW+1:0] code,
    input  logic [TW-1:0] trim,
    output logic          pwm_lead,
    output logic          pwm_lag,
    output logic          cycle_start
);
    import pwm_dac_pkg::*;

    localparam int DW = CW + 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt_lead;
        logic [CW-1:0] cnt_lag;
        logic [CW-1:0] per;
        logic [CW-1:0] off;
        logic [DW-1:0] duty_lead;
        logic [DW-1:0] duty_lag;
    } state_t;

    state_t st_d, st_q;

    logic [DW-1:0] new_duty_lead, new_duty_lag;
    logic [CW-1:0] new_off, new_lag_start;
    logic [CW-1:0] lag_step;
    logic          at_wrap;

    pwm_code_split #(.DW(DW)) u_split (
        .code      (code),
        .duty_lead (new_duty_lead),
        .duty_lag  (new_duty_lag)
    );

    pwm_phase_offset #(.CW(CW), .TW(TW)) u_phase (
        .period    (period),
        .trim      (trim),
        .offset    (new_off),
        .lag_start (new_lag_start)
    );

    always_comb begin
        st_d     = st_q;
        at_wrap  = (st_q.cnt_lead == st_q.per);
        lag_step = (st_q.cnt_lag == st_q.per) ? '0 : st_q.cnt_lag + ONE;
        if (!enable) begin
            st_d = '0;
        end else if (!st_q.run || at_wrap) begin
            st_d.run       = 1'b1;
            st_d.cnt_lead  = '0;
            st_d.cnt_lag   = new_lag_start;
            st_d.per       = period;
            st_d.off       = new_off;
            st_d.duty_lead = new_duty_lead;
            st_d.duty_lag  = new_duty_lag;
        end else begin
            st_d.cnt_lead = st_q.cnt_lead + ONE;
            st_d.cnt_lag  = lag_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic [CW-1:0] ch_cnt  [NUM_CH];
    logic [DW-1:0] ch_duty [NUM_CH];
    logic          ch_pwm  [NUM_CH];

    always_comb begin
        ch_cnt[CH_LEAD]  = st_q.cnt_lead;
        ch_cnt[CH_LAG]   = st_q.cnt_lag;
        ch_duty[CH_LEAD] = st_q.duty_lead;
        ch_duty[CH_LAG]  = st_q.duty_lag;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_compare #(.CW(CW)) u_cmp (
            .run  (st_q.run),
            .cnt  (ch_cnt[g]),
            .duty (ch_duty[g]),
            .pwm  (ch_pwm[g])
        );
    end

    assign pwm_lead    = ch_pwm[CH_LEAD];
    assign pwm_lag     = ch_pwm[CH_LAG];
    assign cycle_start = st_q.run && (st_q.cnt_lead == '0);

    AST_IDLE_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!pwm_lead && !pwm_lag && !cycle_start)); // R1

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.cnt_lead <= st_q.per && st_q.cnt_lag <= st_q.per)); // R2

    AST_PHASE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |-> (({1'b0, st_q.cnt_lag} + {1'b0, st_q.off}) % ({1'b0, st_q.per} + (CW+1)'(1))
                         == '0)); // R5

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && st_q.cnt_lead != '0)
        |-> ($stable(st_q.duty_lead) && $stable(st_q.duty_lag) && $stable(st_q.per))); // R7

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.run) |-> (st_q.cnt_lead == '0)); // R6
endmodule

// File: tb/pwm_dual_phase_dac_test.sv
module pwm_dual_phase_dac_test;
    localparam int CW = 4;
    localparam int TW = 3;
    localparam int DMAX = (1 << (CW + 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [CW-1:0] period = '0;
    logic [CW+1:0] code = '0;
    logic [TW-1:0] trim = '0;
    logic          pwm_lead, pwm_lag, cycle_start;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_dual_phase_dac #(.CW(CW), .TW(TW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .period      (period),
        .code        (code),
        .trim        (trim),
        .pwm_lead    (pwm_lead),
        .pwm_lag     (pwm_lag),
        .cycle_start (cycle_start)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        int pers[6] = '{0, 1, 2, 5, 8, 15};
        int trims[3] = '{0, 2, 7};
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 reset lead", pwm_lead, 1'b0);
        chk("R1 reset lag", pwm_lag, 1'b0);
        chk("R1 reset strobe", cycle_start, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int pi = 0; pi < 6; pi++) begin
            for (int ti = 0; ti < 3; ti++) begin
                for (int c = 0; c < 64; c++) begin
                    int p, span, half, off, c2, cur, base, dl, dg, ca, cb;
                    p = pers[pi];
                    span = p + 1;
                    half = span / 2;
                    off = (trims[ti] > half) ? 0 : half - trims[ti];   // R5 clamp
                    c2 = 63 - c;
                    period = CW'(p);
                    trim = TW'(trims[ti]);
                    code = 6'(c);
                    enable = 1'b1;
                    for (int k = 0; k < 2 * span; k++) begin
                        @(negedge clk);
                        cur = (k < span) ? c : c2;                      // R7 deferral
                        base = cur >> 1;                                // R4 split
                        dl = base + (cur & 1);
                        if (dl > DMAX) dl = DMAX;
                        dg = base;
                        ca = k % span;                                  // R2, R6
                        cb = (ca + span - off) % span;                  // R5
                        chk("R3/R4 lead level", pwm_lead, logic'(ca < dl));
                        chk("R5/R6 lag level", pwm_lag, logic'(cb < dg));
                        chk("R2 strobe", cycle_start, logic'(ca == 0));
                        if (k == p / 2) code = 6'(c2);                  // R7 mid-period change
                    end
                    enable = 1'b0;
                    @(negedge clk);
                    chk("R1 idle lead", pwm_lead, 1'b0);
                    chk("R1 idle lag", pwm_lag, 1'b0);
                    chk("R1 idle strobe", cycle_start, 1'b0);
                end
            end
        end
        done = 1'b1;
        report();
    end

    initial begin
        int cycles = 0;
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000) begin
                vectors++;
                miscompares++;
                $display("FAIL watchdog: got timeout expected completion");
                report();
            end
        end
    end
endmodule